// File: doc/BRIEF.md
# Clock domain sleep/wake controller

This block supervises one clock domain. The domain is either active, with its clock running and its module reachable, or asleep, with the clock gated. Moving between the two takes a gate or ungate handshake of fixed length, and the block reports each phase on its status outputs: a clock-activity flag, a four-level module idle status and a standby flag. It also drives the enable for an external clock-gating cell.

A 2-bit transition mode, written through a small configuration port, decides the policy. In no-sleep mode the domain never starts a sleep, but a hardware wake request can still bring it up. Forced-wake mode wakes the domain and keeps it awake. In automatic mode hardware decides both ways. Activity on the domain's bus initiator, target accesses and wake requests keep the domain active or wake it. After a programmable window of idle prescaler ticks, the domain goes to sleep. A target access in automatic mode is always granted once the domain is active, and the block wakes the domain for it when needed. The same port holds the divider selects for two asynchronous bridges, which the block decodes into ratios.

Top module: `dom_sleep_ctrl`

## Requirements
- R1: After reset the mode reads 0 and the idle window reads 4. Idle status reads 3, standby reads 1, clock activity reads 0, the gate enable is 0 and no grant is given.
- R2: The fast bridge ratio output is 4 for select codes 0 and 1 and 8 for codes 2 and 3. The slow bridge ratio output is 8 for select 0 and 16 for select 1.
- R3: In mode 0, and in the reserved mode 1, an active domain never starts a sleep. A pulse on the wake request still wakes a gated domain.
- R4: Mode 2 wakes a gated domain with no other input, and the domain then stays active while idle.
- R5: In mode 3, with a tick in every cycle, an active domain whose last activity fell on clock edge E0 enters the sleep handshake at edge E0 + window + 1. Activity means bus initiator activity, a target request or a wake request.
- R6: Every wake or sleep handshake shows idle status 1 for exactly HS_CYC cycles (default 4), and clock activity reads 1 throughout.
- R7: New activity during a sleep handshake aborts it. The domain goes through a new wake handshake of HS_CYC cycles with status 1 and returns to active without ever reading idle status 2.
- R8: In mode 3 a target request wakes a gated domain. The grant is asserted only while the request is present and the domain is active (idle status 0).
- R9: Clock activity reads 0 only while the domain is gated (idle status 2 or 3). The gate enable drops to 0 as soon as a sleep handshake starts.
- R10: A sleep condition that holds during a wake handshake is deferred. With a window of 0, the domain still shows idle status 0 for one cycle after the wake completes, then starts sleeping.
- R11: Standby reads 0 exactly when idle status reads 0. Idle status 2 means asleep after a sleep handshake, and 3 means the post-reset disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Loads all configuration fields |
| cfg_mode_i | input | 2 | Transition mode: 0 no-sleep, 1 reserved (acts as 0), 2 forced wake, 3 automatic |
| cfg_win_i | input | WIN_W | Idle window length in prescaler ticks |
| cfg_fdiv_i | input | 2 | Fast bridge divider select |
| cfg_sdiv_i | input | 1 | Slow bridge divider select |
| tick_i | input | 1 | Prescaler tick, the time unit of the window |
| bus_act_i | input | 1 | Activity on the domain's bus initiator |
| wake_req_i | input | 1 | Hardware wake request |
| tgt_req_i | input | 1 | Access request to the domain's module |
| mode_o | output | 2 | Stored transition mode |
| win_o | output | WIN_W | Stored idle window |
| clk_en_o | output | 1 | Enable for the external clock-gating cell |
| clkact_o | output | 1 | Clock activity: 0 only when definitely gated |
| idle_st_o | output | 2 | 0 functional, 1 in transition, 2 asleep, 3 disabled |
| stby_o | output | 1 | Standby flag |
| gnt_o | output | 1 | Grant for the target request |
| fdiv_ratio_o | output | 4 | Decoded fast bridge ratio (4 or 8) |
| sdiv_ratio_o | output | 5 | Decoded slow bridge ratio (8 or 16) |

## Verification
The divider decode is driven through all eight combinations of the two selects, which separates the paired codes of the fast select from the single slow bit. The sleep/wake function is tried with several stimuli. A lone wake pulse in no-sleep mode shows a wakeup without any later sleep. A single bus activity pulse in automatic mode pins the window count to an exact edge. A held target request separates the grant from the wake itself. Activity injected in the first cycle of a sleep handshake proves the abort path, a window of 0 shows that the sleep is deferred during a wakeup, and a mode change alone shows the forced wake.

// File: rtl/dom_sleep_ctrl.sv
module dom_sleep_ctrl #(
  parameter int WIN_W = 4,
  parameter int HS_CYC = 4,
  parameter logic [WIN_W-1:0] WIN_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [WIN_W-1:0] cfg_win_i,
  input  logic [1:0]       cfg_fdiv_i,
  input  logic             cfg_sdiv_i,
  input  logic             tick_i,
  input  logic             bus_act_i,
  input  logic             wake_req_i,
  input  logic             tgt_req_i,
  output logic [1:0]       mode_o,
  output logic [WIN_W-1:0] win_o,
  output logic             clk_en_o,
  output logic             clkact_o,
  output logic [1:0]       idle_st_o,
  output logic             stby_o,
  output logic             gnt_o,
  output logic [3:0]       fdiv_ratio_o,
  output logic [4:0]       sdiv_ratio_o
);
  localparam int HS_W = $clog2(HS_CYC + 1);
  localparam logic [WIN_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {S_OFF, S_WAKE, S_ACT, S_SLP, S_ASLEEP} st_t;

  st_t              st_q, st_d;
  logic [1:0]       mode_q;
  logic [WIN_W-1:0] win_q, idle_q;
  logic [1:0]       fdiv_q;
  logic             sdiv_q;
  logic [HS_W-1:0]  hs_q;

  wire auto_m   = (mode_q == 2'd3);
  wire force_m  = (mode_q == 2'd2);
  wire busy     = bus_act_i | tgt_req_i | wake_req_i;
  wire wake_go  = force_m | wake_req_i | (auto_m & (bus_act_i | tgt_req_i));
  wire hs_done  = (hs_q == HS_W'(HS_CYC - 1));
  wire sleep_go = auto_m & ~busy & (idle_q >= win_q);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_OFF, S_ASLEEP: if (wake_go) st_d = S_WAKE;
      S_WAKE:          if (hs_done) st_d = S_ACT;
      S_ACT:           if (sleep_go) st_d = S_SLP;
      S_SLP: begin
        if (busy || !auto_m) st_d = S_WAKE;
        else if (hs_done)    st_d = S_ASLEEP;
      end
      default:         st_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      win_q  <= WIN_RST;
      fdiv_q <= 2'd0;
      sdiv_q <= 1'b0;
    end else if (cfg_we_i) begin
      mode_q <= cfg_mode_i;
      win_q  <= cfg_win_i;
      fdiv_q <= cfg_fdiv_i;
      sdiv_q <= cfg_sdiv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_OFF;
      hs_q   <= '0;
      idle_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q || (st_q != S_WAKE && st_q != S_SLP)) hs_q <= '0;
      else                                                   hs_q <= hs_q + 1'b1;
      if (st_q != S_ACT || busy)           idle_q <= '0;
      else if (tick_i && idle_q != CNT_MAX) idle_q <= idle_q + 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      S_ACT:           idle_st_o = 2'd0;
      S_WAKE, S_SLP:   idle_st_o = 2'd1;
      S_ASLEEP:        idle_st_o = 2'd2;
      default:         idle_st_o = 2'd3;
    endcase
  end

  assign mode_o       = mode_q;
  assign win_o        = win_q;
  assign clk_en_o     = (st_q == S_WAKE) || (st_q == S_ACT);
  assign clkact_o     = (st_q == S_WAKE) || (st_q == S_ACT) || (st_q == S_SLP);
  assign stby_o       = (st_q != S_ACT);
  assign gnt_o        = tgt_req_i && (st_q == S_ACT);
  assign fdiv_ratio_o = (fdiv_q >= 2'd2) ? 4'd8 : 4'd4;
  assign sdiv_ratio_o = sdiv_q ? 5'd16 : 5'd8;
endmodule

module dom_sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       clk_en_o,
  input logic       clkact_o,
  input logic [1:0] idle_st_o,
  input logic       stby_o,
  input logic       gnt_o,
  input logic       tgt_req_i,
  input logic [3:0] fdiv_ratio_o,
  input logic [4:0] sdiv_ratio_o
);
  a_r2_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (fdiv_ratio_o == 4'd4 || fdiv_ratio_o == 4'd8) && (sdiv_ratio_o == 5'd8 || sdiv_ratio_o == 5'd16));
  a_r3_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_st_o == 2'd0 && mode_o != 2'd3) |=> idle_st_o == 2'd0);
  a_r6_trans_clk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_st_o == 2'd1 |-> clkact_o);
  a_r7_asleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
    idle_st_o == 2'd2 |=> (idle_st_o == 2'd2 || idle_st_o == 2'd1));
  a_r8_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |-> (tgt_req_i && idle_st_o == 2'd0));
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !clkact_o |-> (!clk_en_o && idle_st_o[1]));
  a_r11_stby: assert property (@(posedge clk) disable iff (!rst_n)
    stby_o == (idle_st_o != 2'd0));
endmodule

bind dom_sleep_ctrl dom_sleep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .clk_en_o(clk_en_o),
  .clkact_o(clkact_o), .idle_st_o(idle_st_o), .stby_o(stby_o), .gnt_o(gnt_o),
  .tgt_req_i(tgt_req_i), .fdiv_ratio_o(fdiv_ratio_o), .sdiv_ratio_o(sdiv_ratio_o)
);

// File: tb/dom_sleep_ctrl_tb.sv
module dom_sleep_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sdiv = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_fdiv = 2'd0;
  logic [3:0] cfg_win = 4'd4;
  logic tick = 1'b1, bus_act = 1'b0, wake_req = 1'b0, tgt_req = 1'b0;
  logic [1:0] mode_o, idle_st;
  logic [3:0] win_o, fdiv_ratio;
  logic [4:0] sdiv_ratio;
  logic clk_en, clkact, stby, gnt;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dom_sleep_ctrl #(.WIN_W(4), .HS_CYC(HS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_win_i(cfg_win), .cfg_fdiv_i(cfg_fdiv), .cfg_sdiv_i(cfg_sdiv),
    .tick_i(tick), .bus_act_i(bus_act), .wake_req_i(wake_req), .tgt_req_i(tgt_req),
    .mode_o(mode_o), .win_o(win_o), .clk_en_o(clk_en), .clkact_o(clkact),
    .idle_st_o(idle_st), .stby_o(stby), .gnt_o(gnt),
    .fdiv_ratio_o(fdiv_ratio), .sdiv_ratio_o(sdiv_ratio)
  );

  // {fdiv sel, sdiv sel, expected fast ratio, expected slow ratio}
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 1'b0, 4'd4, 5'd8},  {2'd1, 1'b1, 4'd4, 5'd16},
    {2'd2, 1'b0, 4'd8, 5'd8},  {2'd3, 1'b1, 4'd8, 5'd16},
    {2'd0, 1'b1, 4'd4, 5'd16}, {2'd1, 1'b0, 4'd4, 5'd8},
    {2'd2, 1'b1, 4'd8, 5'd16}, {2'd3, 1'b0, 4'd8, 5'd8}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [3:0] w);
    cfg_we = 1'b1; cfg_mode = m; cfg_win = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count_while(input logic [1:0] v, output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (idle_st != v) break;
      n++;
    end
  endtask

  int n;
  int seen2;

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 idle", idle_st, 3); check("R1 stby", stby, 1);
    check("R1 clkact", clkact, 0); check("R1 clk_en", clk_en, 0);
    check("R1 gnt", gnt, 0); check("R1 win", win_o, 4); check("R1 mode", mode_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: divider decode table (mode 0, no wake: domain stays off)
    for (int i = 0; i < 8; i++) begin
      cfg_fdiv = VEC[i][11:10]; cfg_sdiv = VEC[i][9];
      cfg(2'd0, 4'd4);
      check("R2 fast ratio", fdiv_ratio, int'(VEC[i][8:5]));
      check("R2 slow ratio", sdiv_ratio, int'(VEC[i][4:0]));
    end
    check("R3 no self wake in mode 0", idle_st, 3);

    // R3/R6: wake pulse in no-sleep mode
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    check("R6 wake status", idle_st, 1); check("R6 clkact in wake", clkact, 1);
    count_while(2'd1, n);
    check("R6 wake handshake length", n + 1, HS);
    check("R3 woken in mode 0", idle_st, 0); check("R11 stby active", stby, 0);
    repeat (40) @(negedge clk);
    check("R3 mode 0 stays active", idle_st, 0);
    cfg(2'd1, 4'd0);
    repeat (40) @(negedge clk);
    check("R3 reserved mode stays active", idle_st, 0);

    // R5: window of 2 measured from one activity pulse
    bus_act = 1'b1;
    cfg(2'd3, 4'd2);
    bus_act = 1'b0;
    count_while(2'd0, n);
    check("R5 idle cycles before sleep", n, 2);
    check("R9 gate enable drops in sleep", clk_en, 0);
    check("R9 clkact in sleep handshake", clkact, 1);
    count_while(2'd1, n);
    check("R6 sleep handshake length", n + 1, HS);
    check("R11 asleep status", idle_st, 2); check("R11 stby asleep", stby, 1);
    check("R9 clkact gated", clkact, 0);

    // R8: target request wakes and is granted only when active
    tgt_req = 1'b1;
    @(negedge clk);
    check("R8 waking on request", idle_st, 1); check("R8 no early grant", gnt, 0);
    count_while(2'd1, n);
    check("R8 active after request", idle_st, 0); check("R8 grant", gnt, 1);
    repeat (10) @(negedge clk);
    check("R8 held request keeps active", idle_st, 0);
    tgt_req = 1'b0;
    #1 check("R8 grant follows request", gnt, 0);

    // R7: abort in first sleep handshake cycle
    count_while(2'd0, n);
    check("R7 entered sleep", idle_st, 1);
    bus_act = 1'b1;
    @(negedge clk);
    bus_act = 1'b0;
    check("R7 abort status", idle_st, 1); check("R7 clk_en back", clk_en, 1);
    count_while(2'd1, n);
    check("R7 abort wake length", n + 1, HS);
    check("R7 back active", idle_st, 0);

    // R10: deferral with window 0
    count_while(2'd0, n);
    count_while(2'd1, n);
    check("R10 asleep first", idle_st, 2);
    cfg(2'd3, 4'd0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    count_while(2'd1, n);
    check("R10 full wake handshake", n + 1, HS);
    check("R10 one active cycle", idle_st, 0);
    @(negedge clk);
    check("R10 sleep after active", idle_st, 1);

    // R4: forced wake
    count_while(2'd1, n);
    check("R4 asleep before force", idle_st, 2);
    cfg(2'd2, 4'd0);
    seen2 = 0;
    for (int k = 0; k < 30 && idle_st != 2'd0; k++) @(negedge clk);
    check("R4 forced wake reached", idle_st, 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (idle_st != 2'd0) seen2 = 1;
    end
    check("R4 stays active", seen2, 0);

    // R1: reset again
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset idle", idle_st, 3); check("R1 reset win", win_o, 4);
    check("R1 reset mode", mode_o, 0); check("R1 reset clk_en", clk_en, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule